// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block gathers 32 raw interrupt request lines and routes each one to one of two processor interrupt outputs: the normal request (IRQ) or the fast request (FIQ). Each source has its own enable bit, a routing bit, a 32-bit handler address and a 4-bit priority level. All of these live in a memory-mapped register space. A simple single-cycle bus writes them on the clock edge and reads them back combinationally.

Among the active IRQ-routed sources, an arbiter picks a winner. The lowest priority value wins, and on a tie the lowest source number wins. The winner's handler address is latched into a current-address register, which the interrupt handler reads to find its entry point. This register is loaded only while no interrupt is in service. Loading it starts a service period. Any write to the current-address register ends that period, and the next winner is then loaded one cycle later.

Top module: `vic_core`

## Requirements
- R1: A read at offset 0x008 returns `req_i` unchanged, whatever the enable and routing settings are.
- R2: Writing to offset 0x010 sets every enable bit whose data bit is 1 and leaves the others unchanged. A read at 0x010 returns the enable bits.
- R3: Writing to offset 0x014 clears every enable bit whose data bit is 1 and leaves the others unchanged. A read at 0x014 returns zero.
- R4: Offset 0x00C is a read/write routing register. A bit value of 0 routes the source to IRQ and 1 routes it to FIQ.
- R5: A read at offset 0x000 returns `req_i & enable & ~route`.
- R6: `irq_o` is high exactly when the value read at 0x000 is nonzero. `fiq_o` is high exactly when `req_i & enable & route` is nonzero.
- R7: The handler address of source n is a 32-bit read/write register at 0x100+4n. The priority of source n sits in bits [3:0] of 0x200+4n; the upper bits are ignored on write and read as zero.
- R8: Arbitration among the IRQ status bits selects the lowest priority value, and on a tie the lowest source number.
- R9: Offset 0xF00 reads the current address. When no interrupt is in service and some IRQ status bit is set, the register loads the winner's handler address on the next clock edge and service begins. While in service, the register holds its value.
- R10: Any write to 0xF00 ends service, and the written data is not stored. On the edge after the write, the current winner (if any) is loaded.
- R11: After reset: all enable and routing bits are 0, all handler addresses are 0, all priorities are 15, the current address is 0, and both outputs are low.
- R12: Reads at unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 32 | Raw interrupt request lines, active high |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset into the register space |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the offset |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
On every cycle, the assertions check four things: an output request never appears without a raw request line and an enabled source; the arbiter's winner is always a pending IRQ source; the current address stays stable throughout service; and a write to 0xF00 always ends service. Only the bench's scenarios can show that the chosen vector is the correct one under the priority and tie rules, that set and clear writes leave untouched bits alone, and that register read-back and ignored offsets behave as required. The bench sweeps all 32 single-source cases and a series of mixed request patterns, and computes each expected winner arithmetically from a known priority table.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_IRQ_STAT = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_RAW      = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_ROUTE    = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_CUR      = 12'hF00;
    localparam logic [3:0]        PAGE_VECT    = 4'h1;
    localparam logic [3:0]        PAGE_PRIO    = 4'h2;
endpackage

// File: rtl/vic_mask.sv
module vic_mask #(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] route_i,
    output logic [NSRC-1:0] irq_stat_o,
    output logic [NSRC-1:0] fiq_stat_o,
    output logic            irq_any_o,
    output logic            fiq_any_o
);
    always_comb begin
        irq_stat_o = req_i & en_i & ~route_i;
        fiq_stat_o = req_i & en_i & route_i;
        irq_any_o  = |irq_stat_o;
        fiq_any_o  = |fiq_stat_o;
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]             pend_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    output logic                        valid_o,
    output logic [IDX_W-1:0]            idx_o
);
    always_comb begin
        logic [PRIO_W-1:0] best;
        valid_o = 1'b0;
        idx_o   = '0;
        best    = '1;
        // ascending scan with strict compare: ties keep the lower index
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && (!valid_o || prio_i[i] < best)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                best    = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);
    typedef struct packed {
        logic [NSRC-1:0]             en;
        logic [NSRC-1:0]             route;
        logic [NSRC-1:0][DATA_W-1:0] vect;
        logic [NSRC-1:0][PRIO_W-1:0] prio;
        logic [DATA_W-1:0]           cur;
        logic                        busy;
    } state_t;

    state_t st_d, st_q;

    logic [NSRC-1:0]  irq_stat, fiq_stat;
    logic             irq_any, fiq_any;
    logic             arb_valid;
    logic [IDX_W-1:0] arb_idx;

    vic_mask #(.NSRC(NSRC)) u_mask (
        .req_i      (req_i),
        .en_i       (st_q.en),
        .route_i    (st_q.route),
        .irq_stat_o (irq_stat),
        .fiq_stat_o (fiq_stat),
        .irq_any_o  (irq_any),
        .fiq_any_o  (fiq_any)
    );

    vic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .pend_i  (irq_stat),
        .prio_i  (st_q.prio),
        .valid_o (arb_valid),
        .idx_o   (arb_idx)
    );

    // address decode
    logic       wr;
    logic [5:0] slot;
    logic       slot_ok, on_vect, on_prio, wr_cur;

    always_comb begin
        wr      = bus_sel_i & bus_wr_i;
        slot    = bus_addr_i[7:2];
        slot_ok = (32'(slot) < NSRC) && (bus_addr_i[1:0] == 2'b00);
        on_vect = slot_ok && (bus_addr_i[11:8] == PAGE_VECT);
        on_prio = slot_ok && (bus_addr_i[11:8] == PAGE_PRIO);
        wr_cur  = wr && (bus_addr_i == OFS_CUR);
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (bus_addr_i == OFS_EN_SET) st_d.en    = st_q.en | bus_wdata_i[NSRC-1:0];
            if (bus_addr_i == OFS_EN_CLR) st_d.en    = st_q.en & ~bus_wdata_i[NSRC-1:0];
            if (bus_addr_i == OFS_ROUTE)  st_d.route = bus_wdata_i[NSRC-1:0];
            if (on_vect) st_d.vect[slot[IDX_W-1:0]] = bus_wdata_i;
            if (on_prio) st_d.prio[slot[IDX_W-1:0]] = bus_wdata_i[PRIO_W-1:0];
        end
        if (wr_cur) begin
            st_d.busy = 1'b0;
        end else if (!st_q.busy && arb_valid) begin
            st_d.cur  = st_q.vect[arb_idx];
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en    <= '0;
            st_q.route <= '0;
            st_q.vect  <= '0;
            st_q.prio  <= '1;
            st_q.cur   <= '0;
            st_q.busy  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata_o = '0;
        if (on_vect) begin
            bus_rdata_o = st_q.vect[slot[IDX_W-1:0]];
        end else if (on_prio) begin
            bus_rdata_o = DATA_W'(st_q.prio[slot[IDX_W-1:0]]);
        end else begin
            case (bus_addr_i)
                OFS_IRQ_STAT: bus_rdata_o = DATA_W'(irq_stat);
                OFS_RAW:      bus_rdata_o = DATA_W'(req_i);
                OFS_ROUTE:    bus_rdata_o = DATA_W'(st_q.route);
                OFS_EN_SET:   bus_rdata_o = DATA_W'(st_q.en);
                OFS_CUR:      bus_rdata_o = st_q.cur;
                default:      bus_rdata_o = '0;
            endcase
        end
    end

    assign irq_o = irq_any;
    assign fiq_o = fiq_any;

    // assertions
    a_r6_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|req_i));
    a_r6_fiq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (|st_q.en));
    a_r8_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |-> irq_stat[arb_idx]);
    a_r9_hold_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !wr_cur) |=> $stable(st_q.cur));
    a_r10_write_ends_service: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur |=> !st_q.busy);
    a_r3_clear_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr_i == OFS_EN_CLR && bus_wdata_i[0]) |=> !st_q.en[0]);
endmodule

// File: tb/test_vic_core.sv
module test_vic_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vic_core i_vic_core (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    function automatic logic [3:0] prio_of(int i);
        return 4'((i * 7 + 3) % 16);
    endfunction

    function automatic logic [31:0] vect_of(int i);
        return 32'h4000_0000 + 32'(i) * 32'h104;
    endfunction

    function automatic int exp_win(logic [31:0] p);
        int best = -1;
        for (int i = 0; i < 32; i++)
            if (p[i] && (best < 0 || prio_of(i) < prio_of(best))) best = i;
        return best;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; wr = 0;
    endtask

    task automatic bread(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1; wr = 0; addr = a;
        #1 d = rdata;
        sel = 0;
    endtask

    task automatic set_req(logic [31:0] v);
        @(negedge clk);
        req = v;
    endtask

    // release service, let the next winner load, return it
    task automatic next_vec(output logic [31:0] d);
        bwrite(12'hF00, 32'hDEAD_BEEF);
        @(negedge clk);
        bread(12'hF00, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, en, rt, pat;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R11 reset state
        bread(12'h010, d); chk("R11 enable", d, 0);
        bread(12'h00C, d); chk("R11 route", d, 0);
        bread(12'hF00, d); chk("R11 cur", d, 0);
        bread(12'h204, d); chk("R11 prio", d, 32'hF);
        bread(12'h17C, d); chk("R11 vect", d, 0);
        chk("R11 irq", 32'(irq), 0);
        chk("R11 fiq", 32'(fiq), 0);

        // R1 raw status ignores masking
        set_req(32'hA5A5_0F0F);
        bread(12'h008, d); chk("R1 raw", d, 32'hA5A5_0F0F);
        set_req(0);

        // R2 set-only enable
        bwrite(12'h010, 32'h0000_00FF);
        bread(12'h010, d); chk("R2 set", d, 32'h0000_00FF);
        bwrite(12'h010, 32'h0000_FF00);
        bread(12'h010, d); chk("R2 accumulate", d, 32'h0000_FFFF);
        bwrite(12'h010, 0);
        bread(12'h010, d); chk("R2 zero no effect", d, 32'h0000_FFFF);

        // R3 clear-only enable
        bwrite(12'h014, 32'h0000_000F);
        bread(12'h010, d); chk("R3 clear", d, 32'h0000_FFF0);
        bwrite(12'h014, 0);
        bread(12'h010, d); chk("R3 zero no effect", d, 32'h0000_FFF0);
        bread(12'h014, d); chk("R3 reads zero", d, 0);

        // R4 route register
        bwrite(12'h00C, 32'h0000_00F0);
        bread(12'h00C, d); chk("R4 route readback", d, 32'h0000_00F0);
        set_req(32'h0000_0030);
        @(negedge clk); #1;
        chk("R4 fiq routed", 32'(fiq), 1);
        chk("R4 irq not routed", 32'(irq), 0);
        set_req(32'h0000_0300);
        bread(12'h000, d); chk("R5 status", d, 32'h0000_0300);
        chk("R6 irq", 32'(irq), 1);
        chk("R6 fiq", 32'(fiq), 0);

        // R5/R6 sweep of masks and patterns
        pat = 32'h1234_5678;
        for (int k = 0; k < 40; k++) begin
            en = pat ^ 32'h5A5A_5A5A;
            pat = pat * 32'd1103515245 + 32'd12345;
            rt = pat;
            pat = pat * 32'd1103515245 + 32'd12345;
            if (k % 5 == 0) rt = 32'hFFFF_FFFF;
            bwrite(12'h010, en);
            bwrite(12'h014, ~en);
            bwrite(12'h00C, rt);
            set_req(pat & 32'h0F0F_F0F1);
            bread(12'h000, d);
            chk("R5 status sweep", d, req & en & ~rt);
            chk("R6 irq sweep", 32'(irq), 32'(|(req & en & ~rt)));
            chk("R6 fiq sweep", 32'(fiq), 32'(|(req & en & rt)));
        end
        set_req(0);

        // R7 vector and priority registers
        for (int i = 0; i < 32; i++) begin
            bwrite(12'h100 + 12'(4 * i), vect_of(i));
            bwrite(12'h200 + 12'(4 * i), 32'hFFFF_FFF0 | 32'(prio_of(i)));
        end
        for (int i = 0; i < 32; i++) begin
            bread(12'h100 + 12'(4 * i), d); chk("R7 vect", d, vect_of(i));
            bread(12'h200 + 12'(4 * i), d); chk("R7 prio", d, 32'(prio_of(i)));
        end

        // R8/R9/R10 arbitration
        bwrite(12'h010, 32'hFFFF_FFFF);
        bwrite(12'h00C, 0);
        for (int i = 0; i < 32; i++) begin
            set_req(32'h1 << i);
            next_vec(d); chk("R9 single source", d, vect_of(i));
        end
        // R8 ties: sources i and i+16 share a level
        set_req(32'h0001_0001 << 5);
        next_vec(d); chk("R8 tie lower index", d, vect_of(5));
        pat = 32'hCAFE_0001;
        for (int k = 0; k < 30; k++) begin
            pat = pat * 32'd1103515245 + 32'd12345;
            if (pat == 0) pat = 1;
            set_req(pat);
            next_vec(d); chk("R8 pattern winner", d, vect_of(exp_win(pat)));
        end

        // R9 hold while in service; R10 release loads new winner
        // source 3 has priority 8, source 2 has priority 1
        set_req(32'h1 << 3);
        next_vec(d); chk("R9 load", d, vect_of(3));
        set_req((32'h1 << 3) | (32'h1 << 2));
        repeat (3) @(negedge clk);
        bread(12'hF00, d); chk("R9 held", d, vect_of(3));
        next_vec(d); chk("R10 reload after release", d, vect_of(2));
        set_req(0);
        bwrite(12'hF00, 32'h1111_2222);
        repeat (2) @(negedge clk);
        bread(12'hF00, d); chk("R10 data not stored", d, vect_of(2));

        // R12 unmapped offsets
        bwrite(12'h300, 32'hFFFF_FFFF);
        bwrite(12'h018, 32'hFFFF_FFFF);
        bread(12'h300, d); chk("R12 unmapped read", d, 0);
        bread(12'h004, d); chk("R12 unmapped read 004", d, 0);
        bread(12'h00C, d); chk("R12 route untouched", d, 0);
        bwrite(12'h014, 32'h0000_0001);
        bwrite(12'h018, 32'h0000_0001);
        bread(12'h010, d); chk("R12 enable untouched", d, 32'hFFFF_FFFE);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule